// File: doc/BRIEF.md
# Floating Compare Unit

This block compares two 64-bit operands in the binary64 layout (sign in bit 63, exponent in bits 62:52, fraction in bits 51:0). A 2-bit predicate select picks one of four tests: unordered, equal, less-than and less-or-equal. The answer is a 64-bit word that holds the value 2.0 when the test is true and all zeros when it is false. An invalid-operation flag comes out beside the result.

Each operand is first put in one of these classes: zero, finite, denormal, infinity, quiet NaN or signaling NaN. A control input makes denormals count as zeros. Negative zero is treated as positive zero. The ordering is decided by sign first, then by the exponent and fraction taken together as one magnitude. The result and the flag are registered, so they appear one clock after the inputs are sampled.

Top module: `fcmpUnit`

## Requirements
- R1: With predicate select 0 (unordered), the result is true when either operand is a NaN, meaning an all-ones exponent with a nonzero fraction, and false otherwise.
- R2: With predicate select 1 (equal), 2 (less-than) or 3 (less-or-equal), a NaN on either side makes the result false.
- R3: Less-than and less-or-equal raise invalid whenever either operand is a NaN, quiet or signaling. Equal and unordered given only quiet NaNs (fraction bit 51 set) leave invalid low.
- R4: A zero operand compares with its sign forced positive. So -0 equals +0, -0 < +0 is false, and -0 <= +0 is true.
- R5: Ordering uses the sign first, and a negative operand is the smaller one. For equal signs the {exponent, fraction} magnitudes decide, and the direction is reversed when both operands are negative.
- R6: An all-ones exponent with a zero fraction is an ordered infinity that lies beyond every finite value. A NaN with fraction bit 51 clear is signaling and raises invalid under every predicate.
- R7: When the denormals-to-zero input is 1, a zero-exponent operand with a nonzero fraction is compared as +0 and raises no invalid.
- R8: When the denormals-to-zero input is 0, such a denormal operand raises invalid under every predicate and still compares by magnitude.
- R9: A true result is 0x4000000000000000 and a false result is 0. No other value ever appears on the result.
- R10: The result and invalid reflect the inputs sampled at the previous rising clock edge. An active-low reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 64 | Left operand |
| opB | input | 64 | Right operand |
| predSel | input | 2 | 0 unordered, 1 equal, 2 less-than, 3 less-or-equal |
| flushDenorm | input | 1 | Treat denormal operands as zero |
| result | output | 64 | 0x4000000000000000 when true, 0 when false |
| invalid | output | 1 | Invalid-operation flag |

## Verification
On every cycle the assertions check the legal result encoding, the NaN rules (unordered true, ordered predicates false, invalid from less-than and less-or-equal), signed-zero equality, signaling NaN invalid, and the reset state. The sign-then-magnitude ordering of negative and positive finite numbers and infinities cannot be shown by the assertions. The same holds for denormals under both flush settings and for the exact one-cycle alignment of each answer with its inputs. The bench's scoreboard shows these through chosen operand pairs.

// File: rtl/fcmpPkg.sv
package fcmpPkg;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;

  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_FIN    = 3'd1,
    CLS_DENORM = 3'd2,
    CLS_INF    = 3'd3,
    CLS_QNAN   = 3'd4,
    CLS_SNAN   = 3'd5
  } opClass_e;

  typedef enum logic [1:0] {
    PRED_UNORD = 2'd0,
    PRED_EQ    = 2'd1,
    PRED_LT    = 2'd2,
    PRED_LE    = 2'd3
  } pred_e;

  // strobes from control to datapath: which relation feeds the result
  typedef struct packed {
    logic pickUnord;
    logic pickEq;
    logic pickLt;
    logic pickLe;
  } cmpStrobe_t;
endpackage

// File: rtl/fcmpClassify.sv
module fcmpClassify
  import fcmpPkg::*;
#(
  parameter int EXP_W  = fcmpPkg::EXP_W,
  parameter int FRAC_W = fcmpPkg::FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0]        op,
  input  logic                     flushDenorm,
  output opClass_e                 cls,
  output logic                     keySign,
  output logic [EXP_W+FRAC_W-1:0]  keyMag
);
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic expZero, expOnes, fracZero;

  assign expField  = op[WORD_W-2 -: EXP_W];
  assign fracField = op[FRAC_W-1:0];
  assign expZero   = (expField == '0);
  assign expOnes   = (expField == '1);
  assign fracZero  = (fracField == '0);

  always_comb begin
    if (expZero && fracZero)      cls = CLS_ZERO;
    else if (expZero)             cls = flushDenorm ? CLS_ZERO : CLS_DENORM;
    else if (expOnes && fracZero) cls = CLS_INF;
    else if (expOnes)             cls = fracField[FRAC_W-1] ? CLS_QNAN : CLS_SNAN;
    else                          cls = CLS_FIN;
  end

  // zeros (true or flushed) compare as +0 with null magnitude; a denormal's
  // raw magnitude orders the same way as its normalized form
  assign keySign = (cls == CLS_ZERO) ? 1'b0 : op[WORD_W-1];
  assign keyMag  = (cls == CLS_ZERO) ? '0 : op[WORD_W-2:0];
endmodule

// File: rtl/fcmpControl.sv
module fcmpControl
  import fcmpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] predSel,
  input  opClass_e   clsA,
  input  opClass_e   clsB,
  output cmpStrobe_t strobe,
  output logic       invalid
);
  logic anyNan, classInv, orderedPred, invNext;

  always_comb begin
    strobe = '0;
    unique case (pred_e'(predSel))
      PRED_UNORD: strobe.pickUnord = 1'b1;
      PRED_EQ:    strobe.pickEq    = 1'b1;
      PRED_LT:    strobe.pickLt    = 1'b1;
      default:    strobe.pickLe    = 1'b1;
    endcase
  end

  assign anyNan = (clsA == CLS_QNAN) || (clsA == CLS_SNAN) ||
                  (clsB == CLS_QNAN) || (clsB == CLS_SNAN);
  // raised while classifying, whatever the predicate
  assign classInv = (clsA == CLS_SNAN) || (clsB == CLS_SNAN) ||
                    (clsA == CLS_DENORM) || (clsB == CLS_DENORM);
  assign orderedPred = strobe.pickLt || strobe.pickLe;
  assign invNext = classInv || (orderedPred && anyNan);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) invalid <= 1'b0;
    else       invalid <= invNext;
  end
endmodule

// File: rtl/fcmpDatapath.sv
module fcmpDatapath
  import fcmpPkg::*;
#(
  parameter int EXP_W  = fcmpPkg::EXP_W,
  parameter int FRAC_W = fcmpPkg::FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int MAG_W  = EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              flushDenorm,
  input  cmpStrobe_t        strobe,
  output opClass_e          clsA,
  output opClass_e          clsB,
  output logic [WORD_W-1:0] result
);
  // 2.0: exponent field equals the bias plus one, i.e. only its top bit set
  localparam logic [WORD_W-1:0] TRUE_WORD = {2'b01, {(WORD_W-2){1'b0}}};

  logic [WORD_W-1:0] opArr   [2];
  opClass_e          clsArr  [2];
  logic              signArr [2];
  logic [MAG_W-1:0]  magArr  [2];

  assign opArr[0] = opA;
  assign opArr[1] = opB;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmpClassify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op          (opArr[i]),
      .flushDenorm (flushDenorm),
      .cls         (clsArr[i]),
      .keySign     (signArr[i]),
      .keyMag      (magArr[i])
    );
  end

  assign clsA = clsArr[0];
  assign clsB = clsArr[1];

  logic anyNan, isEq, isLt, magLess, truth;

  assign anyNan  = (clsArr[0] == CLS_QNAN) || (clsArr[0] == CLS_SNAN) ||
                   (clsArr[1] == CLS_QNAN) || (clsArr[1] == CLS_SNAN);
  assign magLess = magArr[0] < magArr[1];
  assign isEq    = (signArr[0] == signArr[1]) && (magArr[0] == magArr[1]);

  always_comb begin
    if (signArr[0] != signArr[1])       isLt = signArr[0];
    else if (magArr[0] == magArr[1])    isLt = 1'b0;
    else                                isLt = signArr[0] ^ magLess;
  end

  assign truth = (strobe.pickUnord && anyNan) ||
                 (!anyNan && ((strobe.pickEq && isEq) ||
                              (strobe.pickLt && isLt) ||
                              (strobe.pickLe && (isLt || isEq))));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) result <= '0;
    else       result <= truth ? TRUE_WORD : '0;
  end
endmodule

// File: rtl/fcmpUnit.sv
module fcmpUnit
  import fcmpPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [1:0]  predSel,
  input  logic        flushDenorm,
  output logic [63:0] result,
  output logic        invalid
);
  opClass_e   clsA, clsB;
  cmpStrobe_t strobe;

  fcmpControl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .predSel (predSel),
    .clsA    (clsA),
    .clsB    (clsB),
    .strobe  (strobe),
    .invalid (invalid)
  );

  fcmpDatapath #(.EXP_W(11), .FRAC_W(52)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .opA         (opA),
    .opB         (opB),
    .flushDenorm (flushDenorm),
    .strobe      (strobe),
    .clsA        (clsA),
    .clsB        (clsB),
    .result      (result)
  );
endmodule

// File: rtl/fcmpChecker.sv
module fcmpChecker (
  input logic        clk,
  input logic        rstN,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic [1:0]  predSel,
  input logic        flushDenorm,
  input logic [63:0] result,
  input logic        invalid
);
  localparam logic [63:0] TRUE_WORD = 64'h4000_0000_0000_0000;

  logic nanA, nanB, snanA, snanB, zeroA, zeroB;
  assign nanA  = (opA[62:52] == 11'h7FF) && (opA[51:0] != '0);
  assign nanB  = (opB[62:52] == 11'h7FF) && (opB[51:0] != '0);
  assign snanA = nanA && !opA[51];
  assign snanB = nanB && !opB[51];
  assign zeroA = (opA[62:0] == '0);
  assign zeroB = (opB[62:0] == '0);

  p_unord_true_r1: assert property (@(posedge clk) disable iff (!rstN)
    (predSel == 2'd0 && (nanA || nanB)) |=> (result == TRUE_WORD));

  p_nan_false_r2: assert property (@(posedge clk) disable iff (!rstN)
    (predSel != 2'd0 && (nanA || nanB)) |=> (result == '0));

  p_ordered_nan_inv_r3: assert property (@(posedge clk) disable iff (!rstN)
    (predSel[1] && (nanA || nanB)) |=> invalid);

  p_signed_zero_eq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (predSel == 2'd1 && zeroA && zeroB) |=> (result == TRUE_WORD));

  p_snan_inv_r6: assert property (@(posedge clk) disable iff (!rstN)
    (snanA || snanB) |=> invalid);

  p_result_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    (result == '0) || (result == TRUE_WORD));

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_clear_r10: assert (result == '0 && !invalid);
    end
  end
endmodule

bind fcmpUnit fcmpChecker u_fcmpChecker (
  .clk         (clk),
  .rstN        (rstN),
  .opA         (opA),
  .opB         (opB),
  .predSel     (predSel),
  .flushDenorm (flushDenorm),
  .result      (result),
  .invalid     (invalid)
);

// File: tb/tb_fcmpUnit.sv
`timescale 1ns/1ps
module tb_fcmpUnit;
  localparam logic [63:0] T_W    = 64'h4000_0000_0000_0000;
  localparam logic [63:0] F_W    = 64'h0;
  localparam logic [63:0] ONE    = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO    = 64'h4000_0000_0000_0000;
  localparam logic [63:0] NONE   = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] NTWO   = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PZ     = 64'h0;
  localparam logic [63:0] NZ     = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PINF   = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF   = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] MAXF   = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] DEN1   = 64'h0000_0000_0000_0001;
  localparam logic [63:0] DEN16  = 64'h0000_0000_0000_0010;
  localparam logic [63:0] NDEN   = 64'h8000_0000_0000_0001;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [1:0]  predSel = '0;
  logic        flushDenorm = 1'b0;
  logic [63:0] result;
  logic        invalid;

  int nChecks = 0;
  int nFails  = 0;
  bit driveDone = 1'b0;

  typedef struct {
    logic [63:0] expRes;
    logic        expInv;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  fcmpUnit dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .predSel(predSel),
    .flushDenorm(flushDenorm), .result(result), .invalid(invalid)
  );

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] sel, input logic fl,
                       input logic [63:0] er, input logic ei, input string tag);
    item_t it;
    @(negedge clk);
    opA = a; opB = b; predSel = sel; flushDenorm = fl;
    it.expRes = er; it.expInv = ei; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: each item pushed before a rising edge shows up just after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        nChecks++;
        if (result !== it.expRes || invalid !== it.expInv) begin
          nFails++;
          $display("FAIL %s: result=%h invalid=%b expected result=%h invalid=%b",
                   it.tag, result, invalid, it.expRes, it.expInv);
        end
      end
    end
  end

  initial begin
    #20000;
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    nChecks++;
    if (result !== '0 || invalid !== 1'b0) begin
      nFails++;
      $display("FAIL R10 reset: result=%h invalid=%b expected 0 0", result, invalid);
    end
    rstN = 1'b1;

    apply(QNAN, ONE,  2'd0, 0, T_W, 0, "R1 unord qnan");
    apply(ONE,  TWO,  2'd0, 0, F_W, 0, "R1 unord ordered");
    apply(QNAN, QNAN, 2'd1, 0, F_W, 0, "R2 R3 eq qnan no invalid");
    apply(QNAN, ONE,  2'd2, 0, F_W, 1, "R3 lt qnan invalid");
    apply(ONE,  QNAN, 2'd3, 0, F_W, 1, "R3 le qnan invalid");
    apply(NZ,   PZ,   2'd1, 0, T_W, 0, "R4 -0 eq +0");
    apply(NZ,   PZ,   2'd2, 0, F_W, 0, "R4 -0 lt +0");
    apply(NZ,   PZ,   2'd3, 0, T_W, 0, "R4 -0 le +0");
    apply(ONE,  TWO,  2'd2, 0, T_W, 0, "R5 1 lt 2");
    apply(TWO,  ONE,  2'd2, 0, F_W, 0, "R5 2 lt 1");
    apply(NTWO, NONE, 2'd2, 0, T_W, 0, "R5 -2 lt -1");
    apply(NONE, NTWO, 2'd2, 0, F_W, 0, "R5 -1 lt -2");
    apply(NONE, ONE,  2'd2, 0, T_W, 0, "R5 -1 lt 1");
    apply(TWO,  TWO,  2'd2, 0, F_W, 0, "R5 equal not lt");
    apply(MAXF, PINF, 2'd2, 0, T_W, 0, "R6 max lt inf");
    apply(NINF, NTWO, 2'd3, 0, T_W, 0, "R6 -inf le -2");
    apply(PINF, PINF, 2'd1, 0, T_W, 0, "R6 inf eq inf");
    apply(SNAN, ONE,  2'd0, 0, T_W, 1, "R6 unord snan");
    apply(SNAN, SNAN, 2'd1, 0, F_W, 1, "R6 eq snan");
    apply(DEN1, PZ,   2'd1, 1, T_W, 0, "R7 flushed denorm eq 0");
    apply(NDEN, PZ,   2'd2, 1, F_W, 0, "R7 flushed -denorm lt 0");
    apply(DEN1, DEN16,2'd2, 0, T_W, 1, "R8 denorm lt denorm");
    apply(DEN1, PZ,   2'd1, 0, F_W, 1, "R8 denorm ne 0");
    apply(PZ,   DEN1, 2'd0, 0, F_W, 1, "R8 unord denorm invalid");
    apply(ONE,  ONE,  2'd3, 0, T_W, 0, "R9 le equal");
    apply(ONE,  ONE,  2'd1, 0, T_W, 0, "R9 eq true word");
    driveDone = 1'b1;
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule